// File: doc/BRIEF.md
# Real-Time Clock Seconds Timebase with Drift Trim

This block turns a slow 32.768 kHz clock-enable strobe into the half-second and one-second events of a real-time clock. Once per counted minute, a signed trim value shortens or stretches the next second. This corrects a crystal that runs fast or slow. The calendar counters above seconds and the alarm comparator sit outside this block. The alarm comparator's pulse comes in as an input so that it can be routed to the output pin.

A single 32-bit control word holds the block's settings: the trim value, the run enable, a stop-on-idle option and the output routing. The run enable is guarded. A write can change it only after a separate unlock bit has already been stored as 1. The control word also returns three live status bits. They show the half-second phase, a near-rollover warning and whether the timebase is currently counting. Only the asynchronous power-on reset clears the word.

Top module: `rtc_timebase`

## Requirements
- R1: After power-on reset, the control word reads 0x00000000, and `sec_pulse`, `half_sec`, `clk_running` and `rtc_out` are all 0.
- R2: Writable fields are trim [25:16], run [15], idle-stop [13], pin-select [7], unlock [3] and pin-enable [0]. Status bits are running [6], near-rollover [2] and half-second [1]. Every other bit reads 0.
- R3: A write changes the run bit only when the unlock bit stored before that write is 1. Otherwise the run bit keeps its value.
- R4: While counting, `sec_pulse` is a one-cycle pulse every 2*HALF_TICKS active ticks. `half_sec` toggles every HALF_TICKS active ticks and falls at each second boundary.
- R5: The trim is a 10-bit two's-complement value N. When N is positive, the second that follows each SECS_PER_MIN-th second boundary is N ticks shorter. N can be up to 511 and must be below HALF_TICKS.
- R6: When N is negative, the second that follows the minute boundary is |N| ticks longer. The divider is held for |N| ticks, down to a value of -512.
- R7: When N is 0, every second lasts exactly 2*HALF_TICKS ticks, including the second after the minute boundary.
- R8: When both idle-stop and `idle` are 1, counting stops and `clk_running` and status bit 6 read 0. Otherwise both follow the run bit.
- R9: While the run bit is 0, the divider holds its state and `sec_pulse` stays 0.
- R10: A high `secs_wr` forces `half_sec` to 0 on the next cycle.
- R11: Status bit 2 is 1 exactly when the divider is within the final SYNC_TICKS ticks before a second rollover.
- R12: `rtc_out` is 0 while pin-enable is 0. Otherwise it carries `sec_pulse` when pin-select is 1 and `alarm_in` when pin-select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Control word with live status bits |
| tick_en | input | 1 | 32.768 kHz clock-enable strobe |
| idle | input | 1 | Processor idle indication |
| secs_wr | input | 1 | Seconds-field write strobe |
| alarm_in | input | 1 | Alarm pulse from the comparator |
| sec_pulse | output | 1 | One-cycle pulse at each second boundary |
| half_sec | output | 1 | Half-second phase |
| clk_running | output | 1 | Timebase is counting |
| rtc_out | output | 1 | Routed output pin |

## Verification
Several properties are checked on every cycle. The divider count stays inside its range, and a seconds pulse never lasts two cycles. The divider freezes while the trim hold runs and while counting is stopped. The locked run bit never moves, and a seconds-field write clears the half-second phase. The exact length of the trimmed second, for positive, negative and zero trim including both extremes, can only be shown by the bench, which times pulse spacing across minute boundaries. The same holds for the position of the near-rollover window, the field layout on readback and the pin routing.

// File: rtl/rtc_time_pkg.sv
package rtc_time_pkg;
  localparam int WORD_W    = 32;
  localparam int TRIM_W    = 10;
  localparam int TRIM_LSB  = 16;
  localparam int B_RUN     = 15;
  localparam int B_IDLSTP  = 13;
  localparam int B_PINSEL  = 7;
  localparam int B_RUNSTAT = 6;
  localparam int B_UNLOCK  = 3;
  localparam int B_NEARROL = 2;
  localparam int B_HALF    = 1;
  localparam int B_PINEN   = 0;

  typedef struct packed {
    logic signed [TRIM_W-1:0] trim;
    logic                     run;
    logic                     idle_stop;
    logic                     pin_sel;
    logic                     unlock;
    logic                     pin_en;
  } rtc_ctrl_t;
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_time_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output rtc_ctrl_t         ctrl_o
);
  rtc_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) begin
      ctrl_d.trim      = wdata_i[TRIM_LSB +: TRIM_W];
      ctrl_d.idle_stop = wdata_i[B_IDLSTP];
      ctrl_d.pin_sel   = wdata_i[B_PINSEL];
      ctrl_d.unlock    = wdata_i[B_UNLOCK];
      ctrl_d.pin_en    = wdata_i[B_PINEN];
      if (ctrl_q.unlock) ctrl_d.run = wdata_i[B_RUN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R3: a locked run bit never moves
  p_run_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.unlock |=> $stable(ctrl_q.run))
    else $error("run bit changed while locked");
endmodule

// File: rtl/rtc_divider.sv
module rtc_divider
  import rtc_time_pkg::*;
#(
  parameter int HALF_TICKS   = 16384,
  parameter int SECS_PER_MIN = 60,
  parameter int SYNC_TICKS   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en_i,
  input  logic                     run_i,
  input  logic                     secs_wr_i,
  input  logic signed [TRIM_W-1:0] trim_i,
  output logic                     sec_pulse_o,
  output logic                     half_o,
  output logic                     near_roll_o
);
  localparam int CNT_W = $clog2(HALF_TICKS);
  localparam int SEC_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_SYNC = CNT_W'(HALF_TICKS - SYNC_TICKS);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS_PER_MIN - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SEC_W-1:0]  sec_q, sec_d;
  logic [TRIM_W-1:0] hold_q, hold_d;
  logic              half_q, half_d;
  logic              pulse_q, pulse_d;
  logic              act;
  logic [TRIM_W-1:0] trim_mag;

  assign act      = tick_en_i & run_i;
  assign trim_mag = TRIM_W'(-trim_i);

  always_comb begin
    cnt_d   = cnt_q;
    sec_d   = sec_q;
    hold_d  = hold_q;
    half_d  = half_q;
    pulse_d = 1'b0;
    if (act) begin
      if (hold_q != '0) begin
        hold_d = hold_q - TRIM_W'(1);
      end else if (cnt_q == CNT_LAST) begin
        cnt_d  = '0;
        half_d = ~half_q;
        if (half_q) begin
          pulse_d = 1'b1;
          if (sec_q == SEC_LAST) begin
            sec_d = '0;
            if (trim_i[TRIM_W-1]) hold_d = trim_mag;
            else                  cnt_d  = CNT_W'($unsigned(trim_i));
          end else begin
            sec_d = sec_q + SEC_W'(1);
          end
        end
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    if (secs_wr_i) half_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sec_q   <= '0;
      hold_q  <= '0;
      half_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sec_q   <= sec_d;
      hold_q  <= hold_d;
      half_q  <= half_d;
      pulse_q <= pulse_d;
    end
  end

  assign sec_pulse_o = pulse_q;
  assign half_o      = half_q;
  assign near_roll_o = half_q & (cnt_q >= CNT_SYNC);

  // R4: count range and single-cycle pulse
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST) else $error("divider out of range");
  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q) else $error("seconds pulse too long");
  // R6: divider frozen during a negative-trim hold
  p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0) |=> $stable(cnt_q)) else $error("divider moved in hold");
  // R8, R9: nothing moves while counting is stopped
  p_stopped_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !secs_wr_i) |=> ($stable(cnt_q) && $stable(half_q) && !pulse_q))
    else $error("divider moved while stopped");
  // R10: seconds write clears half phase
  p_secs_wr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    secs_wr_i |=> !half_q) else $error("half phase survived seconds write");
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_time_pkg::*;
#(
  parameter int HALF_TICKS   = 16384,
  parameter int SECS_PER_MIN = 60,
  parameter int SYNC_TICKS   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_en,
  input  logic        idle,
  input  logic        secs_wr,
  input  logic        alarm_in,
  output logic        sec_pulse,
  output logic        half_sec,
  output logic        clk_running,
  output logic        rtc_out
);
  rtc_ctrl_t ctrl;
  logic      running;
  logic      near_roll;

  rtc_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr),
    .wdata_i (bus_wdata),
    .ctrl_o  (ctrl)
  );

  assign running = ctrl.run & ~(ctrl.idle_stop & idle);

  rtc_divider #(
    .HALF_TICKS   (HALF_TICKS),
    .SECS_PER_MIN (SECS_PER_MIN),
    .SYNC_TICKS   (SYNC_TICKS)
  ) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en_i   (tick_en),
    .run_i       (running),
    .secs_wr_i   (secs_wr),
    .trim_i      (ctrl.trim),
    .sec_pulse_o (sec_pulse),
    .half_o      (half_sec),
    .near_roll_o (near_roll)
  );

  always_comb begin
    bus_rdata                       = '0;
    bus_rdata[TRIM_LSB +: TRIM_W]   = ctrl.trim;
    bus_rdata[B_RUN]                = ctrl.run;
    bus_rdata[B_IDLSTP]             = ctrl.idle_stop;
    bus_rdata[B_PINSEL]             = ctrl.pin_sel;
    bus_rdata[B_RUNSTAT]            = running;
    bus_rdata[B_UNLOCK]             = ctrl.unlock;
    bus_rdata[B_NEARROL]            = near_roll;
    bus_rdata[B_HALF]               = half_sec;
    bus_rdata[B_PINEN]              = ctrl.pin_en;
  end

  assign clk_running = running;
  assign rtc_out     = ctrl.pin_en & (ctrl.pin_sel ? sec_pulse : alarm_in);

  // R11: rollover warning only in the second half of a second
  p_near_in_high_half_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[B_NEARROL] |-> half_sec) else $error("near-rollover outside high half");
endmodule

// File: tb/rtc_timebase_tb.sv
`timescale 1ns/1ps
module rtc_timebase_tb;
  localparam int H = 600;
  localparam int S = 3;
  localparam int Y = 32;

  typedef struct packed {
    logic [9:0]  trim;
    logic [15:0] gap;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{10'h000, 16'd1200},
    '{10'h001, 16'd1199},
    '{10'h064, 16'd1100},
    '{10'h1FF, 16'd689},
    '{10'h3FF, 16'd1201},
    '{10'h3DB, 16'd1237},
    '{10'h200, 16'd1712}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        idle = 1'b0;
  logic        secs_wr = 1'b0;
  logic        alarm_in = 1'b0;
  logic        sec_pulse, half_sec, clk_running, rtc_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_timebase #(.HALF_TICKS(H), .SECS_PER_MIN(S), .SYNC_TICKS(Y)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_en(tick_en), .idle(idle), .secs_wr(secs_wr),
    .alarm_in(alarm_in), .sec_pulse(sec_pulse), .half_sec(half_sec),
    .clk_running(clk_running), .rtc_out(rtc_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic next_pulse(output int t);
    do @(negedge clk); while (!sec_pulse);
    t = cyc;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t [6];
    int seen;
    do_reset();
    // R1: reset state
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 outs", {28'h0, sec_pulse, half_sec, clk_running, rtc_out}, 32'h0);

    // Vector table: trim value against length of the post-minute second (R5 R6 R7)
    tick_en = 1'b1;
    foreach (VECS[i]) begin
      do_reset();
      wr(32'h0000_0008);
      wr({6'h0, VECS[i].trim, 16'h8008});
      for (int k = 1; k <= 5; k++) next_pulse(t[k]);
      chk("R4 normal second", t[3] - t[2], 2 * H);
      if (VECS[i].trim == 10'h0)     chk("R7 zero trim", t[4] - t[3], VECS[i].gap);
      else if (VECS[i].trim[9])      chk("R6 negative trim", t[4] - t[3], VECS[i].gap);
      else                           chk("R5 positive trim", t[4] - t[3], VECS[i].gap);
      chk("R4 second after trim", t[5] - t[4], 2 * H);
    end

    // R2: field layout and unimplemented bits
    tick_en = 1'b0;
    do_reset();
    wr(32'h0000_0008);
    wr(32'hFFFF_FFFF);
    chk("R2 readback", bus_rdata, 32'h03FF_A0C9);

    // R3: run bit locked when unlock stored as 0
    do_reset();
    wr(32'h0000_8000);
    chk("R3 locked run", bus_rdata[15], 1'b0);
    chk("R3 locked status", clk_running, 1'b0);
    wr(32'h0000_0008);
    wr(32'h0000_8000);
    chk("R3 unlocked run", bus_rdata[15], 1'b1);
    wr(32'h0000_0000);
    chk("R3 relock keeps run", bus_rdata[15], 1'b1);

    // R4, R11: half phase width and near-rollover window
    tick_en = 1'b1;
    do @(negedge clk); while (!half_sec);
    repeat (H - Y - 1) @(negedge clk);
    chk("R11 before window", bus_rdata[2], 1'b0);
    @(negedge clk);
    chk("R11 window start", bus_rdata[2], 1'b1);
    repeat (Y - 1) @(negedge clk);
    chk("R4 half still high", half_sec, 1'b1);
    chk("R11 window end", bus_rdata[2], 1'b1);
    @(negedge clk);
    chk("R4 half falls", half_sec, 1'b0);
    chk("R11 cleared", bus_rdata[2], 1'b0);

    // R10: seconds write clears half phase
    do @(negedge clk); while (!half_sec);
    secs_wr = 1'b1;
    @(negedge clk);
    secs_wr = 1'b0;
    chk("R10 half cleared", half_sec, 1'b0);

    // R8: idle stop
    wr(32'h0000_A008);
    idle = 1'b1;
    @(negedge clk);
    chk("R8 stopped status", clk_running, 1'b0);
    chk("R8 stopped rdata", bus_rdata[6], 1'b0);
    seen = 0;
    repeat (2 * H + 10) begin
      @(negedge clk);
      if (sec_pulse) seen++;
    end
    chk("R8 no pulses in idle", seen, 0);
    idle = 1'b0;
    @(negedge clk);
    chk("R8 resumes", clk_running, 1'b1);

    // R9: run bit cleared
    wr(32'h0000_0008);
    seen = 0;
    repeat (2 * H + 10) begin
      @(negedge clk);
      if (sec_pulse) seen++;
    end
    chk("R9 no pulses when off", seen, 0);

    // R12: pin routing
    wr(32'h0000_8008);
    alarm_in = 1'b1;
    @(negedge clk);
    chk("R12 pin disabled", rtc_out, 1'b0);
    wr(32'h0000_8009);
    chk("R12 alarm high", rtc_out, 1'b1);
    alarm_in = 1'b0;
    @(negedge clk);
    chk("R12 alarm low", rtc_out, 1'b0);
    wr(32'h0000_8089);
    alarm_in = 1'b1;
    seen = 0;
    repeat (2 * H + 10) begin
      @(negedge clk);
      if (rtc_out !== sec_pulse) seen++;
      if (sec_pulse && rtc_out) seen += 1000;
    end
    chk("R12 seconds routed", (seen >= 1000) && (seen % 1000 == 0), 1'b1);

    finish_run();
  end
endmodule